// File: doc/BRIEF.md
# Message-Passing Send DMA Engine

The engine lives in a network adapter and moves one message from a tile's private memory onto the network. Software programs a source address, a word count and a destination node through memory-mapped registers. It then writes the message tag. That tag write is the start command.

Once started, the engine first puts a single header beat on its streaming output. The header holds the destination, the word count and the tag. The engine then reads the requested number of consecutive words from its own port of a dual-port memory and sends them as payload beats. The processor keeps running on the other memory port.

The output uses a valid/ready handshake. Reads are issued ahead into a two-entry buffer, so a stalled network loses no word, and a ready network takes one beat per cycle. Software polls a status register for busy and done.

Top module: `sde_top`

## Requirements
- R1: After reset, the status register (address 4) reads 0 and `pkt_valid_o` is low.
- R2: A write to the tag register (address 3) while idle starts a transfer. In the next cycle the status busy bit (bit 0) is 1 and a header beat is offered with `pkt_hdr_o` high. The header data is destination in bits 39:32, word count in bits 31:16 and tag in bits 15:0.
- R3: The payload is exactly word-count beats. Beat k carries the memory word at source address + k in bits 31:0, and bits 39:32 are zero.
- R4: While `pkt_valid_o` is high and `pkt_ready_i` is low, the offered beat stays unchanged. Under any ready pattern, no word is lost or duplicated.
- R5: Busy stays 1 until the last beat is accepted. In the cycle after that acceptance, busy is 0 and the done bit (bit 1) is 1. Done clears when the next transfer starts.
- R6: A tag write while busy is ignored. The tag register reads back its earlier value and no extra packet is sent.
- R7: A word count of 0 sends only the header, with `pkt_last_o` high. The engine is idle in the cycle after that header is accepted.
- R8: `pkt_last_o` is high on the final payload beat and low on every other beat of a packet that has payload.
- R9: Source, count and destination are captured at start. Writes to them during a transfer change their readback but not the packet in progress.
- R10: Register map: 0 source address, 1 word count, 2 destination, 3 tag. Registers 0 to 3 read back the last value they accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory word address |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the request |
| pkt_valid_o | output | 1 | Beat valid |
| pkt_ready_i | input | 1 | Beat accepted by the network |
| pkt_data_o | output | 40 | Beat data |
| pkt_hdr_o | output | 1 | Beat is the header |
| pkt_last_o | output | 1 | Beat is the last of the packet |

## Verification
A wrong buffer count or a wrong read credit shows at the output within a few cycles of a stall. It appears as a payload word that is repeated, skipped or out of order, which the scoreboard reports at the first mismatching beat. A wrong address counter gives data from the wrong memory word on the first affected beat. A wrong remaining-beat counter moves `pkt_last_o` or makes busy clear at the wrong time, which the status poll and the queue check expose at the end of that packet. A tag write that is not ignored shows at once in the tag readback and later as an unexpected header.

// File: rtl/sde_pkg.sv
package sde_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY
  } sde_state_e;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_SIZE = 3'd1;
  localparam logic [2:0] REG_DEST = 3'd2;
  localparam logic [2:0] REG_TAG  = 3'd3;
  localparam logic [2:0] REG_STAT = 3'd4;
endpackage

// File: rtl/sde_regs.sv
module sde_regs
  import sde_pkg::*;
#(
  parameter int AW     = 16,
  parameter int SIZE_W = 16,
  parameter int DEST_W = 8,
  parameter int TAG_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              start_o,
  output logic [AW-1:0]     src_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [DEST_W-1:0] dest_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic [AW-1:0]     src_q;
  logic [SIZE_W-1:0] size_q;
  logic [DEST_W-1:0] dest_q;
  logic [TAG_W-1:0]  tag_q;

  assign start_o = we_i && (addr_i == REG_TAG) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      size_q <= '0;
      dest_q <= '0;
      tag_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_SRC:  src_q  <= wdata_i[AW-1:0];
        REG_SIZE: size_q <= wdata_i[SIZE_W-1:0];
        REG_DEST: dest_q <= wdata_i[DEST_W-1:0];
        REG_TAG:  if (!busy_i) tag_q <= wdata_i[TAG_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      REG_SRC:  rdata_o = REG_W'(src_q);
      REG_SIZE: rdata_o = REG_W'(size_q);
      REG_DEST: rdata_o = REG_W'(dest_q);
      REG_TAG:  rdata_o = REG_W'(tag_q);
      REG_STAT: rdata_o = REG_W'({done_i, busy_i});
      default:  rdata_o = '0;
    endcase
  end

  assign src_o  = src_q;
  assign size_o = size_q;
  assign dest_o = dest_q;
  assign tag_o  = tag_q;

  // R6: a tag write that arrives while busy leaves the tag unchanged
  a_r6_tag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_TAG && busy_i) |=> $stable(tag_o));
endmodule

// File: rtl/sde_fetch.sv
module sde_fetch #(
  parameter int AW     = 16,
  parameter int SIZE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     base_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              room_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o
);
  logic [AW-1:0]     addr_q;
  logic [SIZE_W-1:0] rem_q;

  assign mem_req_o  = (rem_q != '0) && room_i;
  assign mem_addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (start_i) begin
      addr_q <= base_i;
      rem_q  <= size_i;
    end else if (mem_req_o) begin
      addr_q <= addr_q + AW'(1);
      rem_q  <= rem_q - SIZE_W'(1);
    end
  end

  // R3: consecutive reads walk upward one word at a time
  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (mem_addr_o == $past(mem_addr_o) + AW'(1)));
endmodule

// File: rtl/sde_stream.sv
module sde_stream
  import sde_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 16,
  parameter int DEST_W = 8,
  parameter int TAG_W  = 16,
  parameter int BEAT_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DEST_W-1:0] dest_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              room_o,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [BEAT_W-1:0] data_o,
  output logic              hdr_o,
  output logic              last_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int HDR_W = DEST_W + SIZE_W + TAG_W;

  sde_state_e        state_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [SIZE_W-1:0] size_q;
  logic [SIZE_W-1:0] sent_q;
  logic              done_q;
  logic              rvld_q;
  logic [DATA_W-1:0] head_q, pf_q;
  logic [1:0]        occ_q;
  logic              accept, push, pop;
  logic [2:0]        fill;

  assign valid_o = (state_q == ST_HDR) || (state_q == ST_PAY && occ_q != 2'd0);
  assign hdr_o   = (state_q == ST_HDR);
  assign data_o  = hdr_o ? BEAT_W'(hdr_q) : BEAT_W'(head_q);
  assign last_o  = hdr_o ? (size_q == '0) : (sent_q == SIZE_W'(1));
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  assign accept = valid_o && ready_i;
  assign push   = rvld_q;
  assign pop    = accept && (state_q == ST_PAY);
  // words held plus word in flight, after this cycle's pop
  assign fill   = {1'b0, occ_q} + {2'b00, rvld_q} - {2'b00, pop};
  assign room_o = (fill < 3'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      size_q  <= '0;
      sent_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_HDR;
          hdr_q   <= {dest_i, size_i, tag_i};
          size_q  <= size_i;
          sent_q  <= size_i;
          done_q  <= 1'b0;
        end
        ST_HDR: if (accept) begin
          if (size_q == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_PAY;
          end
        end
        ST_PAY: if (pop) begin
          sent_q <= sent_q - SIZE_W'(1);
          if (sent_q == SIZE_W'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // two-entry buffer: head_q is offered, pf_q catches a word during a stall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvld_q <= 1'b0;
      head_q <= '0;
      pf_q   <= '0;
      occ_q  <= 2'd0;
    end else begin
      rvld_q <= req_i;
      case (occ_q)
        2'd0: if (push) begin
          head_q <= rdata_i;
          occ_q  <= 2'd1;
        end
        2'd1: begin
          if (push && pop) head_q <= rdata_i;
          else if (push) begin
            pf_q  <= rdata_i;
            occ_q <= 2'd2;
          end else if (pop) occ_q <= 2'd0;
        end
        default: if (pop) begin
          head_q <= pf_q;
          if (push) pf_q <= rdata_i;
          else occ_q <= 2'd1;
        end
      endcase
    end
  end

  // R4: an offered beat is held until taken
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(hdr_o)));
  // R4: the read credit never lets a word arrive into a full buffer
  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !pop) |-> (occ_q != 2'd2));
endmodule

// File: rtl/sde_top.sv
module sde_top #(
  parameter int AW     = 16,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 16,
  parameter int DEST_W = 8,
  parameter int TAG_W  = 16,
  parameter int REG_W  = 32,
  localparam int HDR_W  = DEST_W + SIZE_W + TAG_W,
  localparam int BEAT_W = (DATA_W > HDR_W) ? DATA_W : HDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              pkt_valid_o,
  input  logic              pkt_ready_i,
  output logic [BEAT_W-1:0] pkt_data_o,
  output logic              pkt_hdr_o,
  output logic              pkt_last_o
);
  logic              start, busy, done, room;
  logic [AW-1:0]     src;
  logic [SIZE_W-1:0] size;
  logic [DEST_W-1:0] dest;
  logic [TAG_W-1:0]  tag;
  logic [TAG_W-1:0]  start_tag;

  // the start write carries the new tag, so take it from the bus
  assign start_tag = reg_wdata_i[TAG_W-1:0];

  sde_regs #(.AW(AW), .SIZE_W(SIZE_W), .DEST_W(DEST_W), .TAG_W(TAG_W), .REG_W(REG_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .busy_i  (busy),
    .done_i  (done),
    .start_o (start),
    .src_o   (src),
    .size_o  (size),
    .dest_o  (dest),
    .tag_o   (tag)
  );

  sde_fetch #(.AW(AW), .SIZE_W(SIZE_W)) i_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .base_i     (src),
    .size_i     (size),
    .room_i     (room),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o)
  );

  sde_stream #(.DATA_W(DATA_W), .SIZE_W(SIZE_W), .DEST_W(DEST_W), .TAG_W(TAG_W),
               .BEAT_W(BEAT_W)) i_stream (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .size_i  (size),
    .dest_i  (dest),
    .tag_i   (start_tag),
    .req_i   (mem_req_o),
    .rdata_i (mem_rdata_i),
    .room_o  (room),
    .ready_i (pkt_ready_i),
    .valid_o (pkt_valid_o),
    .data_o  (pkt_data_o),
    .hdr_o   (pkt_hdr_o),
    .last_o  (pkt_last_o),
    .busy_o  (busy),
    .done_o  (done)
  );

  // R2: the first beat of every transfer is the header
  a_r2_hdr_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> (pkt_valid_o && pkt_hdr_o));
  // R5: the engine is idle right after the last beat is taken
  a_r5_idle_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_ready_i && pkt_last_o) |=> (!busy && done));
  // R2: the engine leaves idle exactly when a start is taken
  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !busy) |=> busy);
  // R6: the tag register reads back its value from before the ignored write
  a_r6_tag_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd3 && busy) |=> (tag == $past(tag)));
endmodule

// File: tb/test_sde_top.sv
module test_sde_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        pvalid, pready = 1'b0, phdr, plast;
  logic [39:0] pdata;

  int vectors = 0;
  int errors = 0;
  int bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [41:0] exp_q[$];
  logic [31:0] mem [256];

  always #2 clk = ~clk;

  sde_top i_sde_top (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .pkt_valid_o(pvalid),
    .pkt_ready_i(pready), .pkt_data_o(pdata), .pkt_hdr_o(phdr), .pkt_last_o(plast)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203) ^ 32'(i);

  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[7:0]];

  // ready driver: 0 always ready, 1 pseudo-random, 2 held low
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (bp_mode)
      0: pready <= 1'b1;
      1: pready <= lfsr[0] ^ lfsr[3];
      default: pready <= 1'b0;
    endcase
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    vectors++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // monitor: compare every accepted beat with the scoreboard head
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && pvalid && pready) begin
        if (exp_q.size() == 0) begin
          check("R6 unexpected beat", {22'd0, phdr, plast, pdata}, 64'hDEAD);
        end else begin
          logic [41:0] e;
          e = exp_q.pop_front();
          check(e[41] ? "R2 header" : "R3/R8 payload",
                {22'd0, phdr, plast, pdata}, {22'd0, e});
        end
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1; d = rdata;
  endtask

  task automatic expect_pkt(int src, int size, int dest, int tag);
    exp_q.push_back({1'b1, (size == 0), dest[7:0], size[15:0], tag[15:0]});
    for (int k = 0; k < size; k++)
      exp_q.push_back({1'b0, (k == size - 1), 8'h00, mem[(src + k) % 256]});
  endtask

  task automatic send(int src, int size, int dest, int tag);
    wr(3'd0, 32'(src));
    wr(3'd1, 32'(size));
    wr(3'd2, 32'(dest));
    expect_pkt(src, size, dest, tag);
    wr(3'd3, 32'(tag));
  endtask

  task automatic wait_idle(string req);
    logic [31:0] s;
    s = 32'h1;
    while (s[0]) rd(3'd4, s);
    check(req, {62'd0, s[1:0]}, 64'h2);
    check({req, " queue"}, 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd4, r); check("R1 status", 64'(r), 64'd0);
    check("R1 valid", {63'd0, pvalid}, 64'd0);
    // R10 readback
    wr(3'd0, 32'h0000_0123); rd(3'd0, r); check("R10 src", 64'(r), 64'h123);
    wr(3'd2, 32'h0000_0045); rd(3'd2, r); check("R10 dest", 64'(r), 64'h45);

    // R2 R3 R8: free-flowing packet
    bp_mode = 0;
    send(10, 4, 3, 16'h1234);
    wait_idle("R5 done after A");
    // R4: random backpressure, longer packet
    bp_mode = 1;
    send(200, 9, 8'hC7, 16'hBEEF);
    wait_idle("R5 done after B");
    send(0, 1, 1, 16'h0001);
    wait_idle("R5 done after C");
    // R7: header only
    bp_mode = 0;
    send(5, 0, 2, 16'h7777);
    wait_idle("R7 idle after header");

    // R6 R9: held transfer, late writes
    bp_mode = 2;
    send(40, 3, 9, 16'hAAAA);
    rd(3'd4, r); check("R5 busy held, done cleared", 64'(r), 64'h1);
    wr(3'd3, 32'h0000_BBBB);
    rd(3'd3, r); check("R6 tag readback", 64'(r), 64'hAAAA);
    wr(3'd1, 32'd7); wr(3'd0, 32'd100);
    rd(3'd1, r); check("R9 size readback", 64'(r), 64'd7);
    repeat (5) @(negedge clk);
    rd(3'd4, r); check("R5 still busy", 64'(r), 64'h1);
    bp_mode = 1;
    wait_idle("R6 R9 done");
    repeat (10) @(negedge clk);
    check("R6 no extra packet", 64'(exp_q.size()), 64'd0);

    // R4: long packet under random stall
    send(17, 20, 4, 16'h0F0F);
    wait_idle("R4 long");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule